// File: doc/BRIEF.md
# Time-Multiplexed Fifth-Order Lattice-Ladder IIR Filter

This block filters a stream of signed fixed-point samples through a fifth-order lattice-ladder IIR structure. Every multiply, add and subtract for one sample runs on a single shared, three-stage pipelined multiply-add unit. A slot controller issues a fixed per-sample program to that unit. The program has a forward lattice chain on the accumulator, backward lattice updates that add a product to a delayed state, and a ladder sum that starts with a plain product and then accumulates. Tags carried through the pipeline steer each result into working registers or onto the output.

The reflection coefficients k1..k5 and the ladder coefficients v0..v5 sit in a small register bank that is loaded through a single write port. Between samples the block holds the delayed backward-path values. At the last slot of each program it commits them from the working registers. A sample that arrives while a program is still running is dropped and reported on a one-cycle overrun strobe.

Top module: `lattice_ladder_iir`

## Requirements
- R1: While rst_ni is low and just after it rises, y_o, y_valid_o and overrun_o are 0. Reset also clears all coefficients and the delayed backward state, so the first output after reset is the response from a zero initial state.
- R2: The forward path computes f4 = x - k5*d4 and then f(m-1) = f(m) - k(m)*d(m-1) for m = 4..1. The subtractions chain in the accumulator at full precision. d(i) is the backward value held from the previous sample.
- R3: The backward path computes g(i) = d(i-1) + k(i)*f(i-1) for i = 1..5, with g0 = f0. Once each sample finishes, the held state becomes d0 = f0 and d(i) = g(i) for i = 1..4. With all k = 0 this makes a tapped delay line, so that v1 alone gives y[n] = x[n-1].
- R4: The output is y = v0*g0 + v1*g1 + ... + v5*g5. It is rounded half up as (acc + 2^15) >> 16 with an arithmetic shift, then saturated to [-131072, 131071].
- R5: y_valid_o is high for exactly one cycle, 20 rising edges after the edge that samples x_valid_i with the sample accepted.
- R6: A sample is accepted when the block is idle or in the last of its 20 slots, so samples can arrive every 20 cycles. Any other x_valid_i is dropped. It raises overrun_o for one cycle after the sampling edge and changes neither the output nor the held state.
- R7: A write with coef_we_i at coef_addr_i 0..4 loads k1..k5, and at 5..10 loads v0..v5. Writes to addresses 11..15 have no effect.
- R8: Samples are 18-bit signed integers and coefficients are 18-bit Q1.16. Each stored f and g value is rounded and saturated to 18 bits in the same way as the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | 18 | Input sample, signed |
| x_valid_i | input | 1 | Input sample strobe |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 4 | Coefficient address (0..4 k1..k5, 5..10 v0..v5) |
| coef_data_i | input | 18 | Coefficient value, Q1.16 |
| y_o | output | 18 | Filtered sample, signed |
| y_valid_o | output | 1 | Output strobe, one cycle |
| overrun_o | output | 1 | One-cycle flag for a dropped input sample |

## Verification
A slot that reads the wrong register, or a result written back under the wrong tag, corrupts y_o on the same sample, 20 cycles after its input. A broken commit of the backward state shows up one sample later. The delay-line case makes that visible at a single tap. A dropped sample that leaks into the state shows as a mismatch on the next accepted sample, so every output is compared against an independent fixed-point model of the recursion. A schedule or commit slip that moves the strobe shows up at once as a y_valid_o edge off cycle 20.

// File: rtl/llf_pkg.sv
package llf_pkg;
  localparam int IW = 4;  // index width, supports order up to 15

  typedef enum logic [2:0] {OP_NOP, OP_MUL, OP_CSUB, OP_CADD, OP_PSUB, OP_PADD} mac_op_e;
  typedef enum logic [1:0] {WB_NONE, WB_F, WB_G, WB_Y} wb_e;
  typedef enum logic [1:0] {SRC_X, SRC_GD, SRC_F, SRC_G} src_e;

  typedef struct packed {
    wb_e           kind;
    logic [IW-1:0] idx;
  } tag_t;

  typedef struct packed {
    mac_op_e       op;
    logic          a_is_v;
    logic [IW-1:0] a_idx;
    src_e          b_src;
    logic [IW-1:0] b_idx;
    src_e          c_src;
    logic [IW-1:0] c_idx;
    tag_t          tag;
  } uop_t;
endpackage

// File: rtl/llf_round.sv
module llf_round #(
  parameter int DW   = 18,
  parameter int FRAC = 16,
  parameter int AW   = 48
) (
  input  logic signed [AW-1:0] p_i,
  output logic signed [DW-1:0] q_o
);
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = ~MAXV;
  localparam logic signed [AW-1:0] HALF = {{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [AW-1:0] sum, sh;
  assign sum = p_i + HALF;
  assign sh  = sum >>> FRAC;

  always_comb begin
    if (sh > MAXV)      q_o = MAXV[DW-1:0];
    else if (sh < MINV) q_o = MINV[DW-1:0];
    else                q_o = sh[DW-1:0];
  end
endmodule

// File: rtl/llf_mac.sv
module llf_mac import llf_pkg::*; #(
  parameter int DW   = 18,
  parameter int FRAC = 16,
  parameter int AW   = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  mac_op_e              op_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  input  tag_t                 tag_i,
  output logic signed [AW-1:0] p_o,
  output tag_t                 tag_o
);
  localparam int PW = 2*DW;

  mac_op_e              op1, op2, op3;
  logic signed [DW-1:0] a1, b1, c1;
  logic signed [AW-1:0] m2, c2;
  tag_t                 tag1, tag2;
  logic signed [PW-1:0] prod;

  assign prod = a1 * b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op1 <= OP_NOP; op2 <= OP_NOP; op3 <= OP_NOP;
      a1 <= '0; b1 <= '0; c1 <= '0;
      m2 <= '0; c2 <= '0; p_o <= '0;
      tag1 <= '0; tag2 <= '0; tag_o <= '0;
    end else begin
      // stage 1: operand registers
      op1 <= op_i; a1 <= a_i; b1 <= b_i; c1 <= c_i; tag1 <= tag_i;
      // stage 2: product, aligned C
      op2  <= op1;
      tag2 <= tag1;
      m2   <= {{(AW-PW){prod[PW-1]}}, prod};
      c2   <= {{(AW-DW-FRAC){c1[DW-1]}}, c1, {FRAC{1'b0}}};
      // stage 3: accumulator with P feedback
      op3   <= op2;
      tag_o <= tag2;
      case (op2)
        OP_MUL:  p_o <= m2;
        OP_CSUB: p_o <= c2 - m2;
        OP_CADD: p_o <= c2 + m2;
        OP_PSUB: p_o <= p_o - m2;
        OP_PADD: p_o <= p_o + m2;
        default: p_o <= p_o;
      endcase
    end
  end

  AST_FWD_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op2 == OP_PSUB) |-> (op3 == OP_CSUB || op3 == OP_PSUB)); // R2
  AST_LADDER_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op2 == OP_PADD) |-> (op3 == OP_MUL || op3 == OP_PADD)); // R4
endmodule

// File: rtl/llf_coef_bank.sv
module llf_coef_bank #(
  parameter int ORDER = 5,
  parameter int DW    = 18,
  parameter int CAW   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CAW-1:0]             addr_i,
  input  logic [DW-1:0]              data_i,
  output logic [ORDER-1:0][DW-1:0]   k_o,
  output logic [ORDER:0][DW-1:0]     v_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_o <= '0;
      v_o <= '0;
    end else if (we_i) begin
      for (int i = 0; i < ORDER; i++)
        if (addr_i == CAW'(i)) k_o[i] <= data_i;
      for (int i = 0; i <= ORDER; i++)
        if (addr_i == CAW'(ORDER + i)) v_o[i] <= data_i;
    end
  end
endmodule

// File: rtl/llf_sched.sv
module llf_sched import llf_pkg::*; #(
  parameter int ORDER = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_valid_i,
  output logic accept_o,
  output logic active_o,
  output logic last_o,
  output logic overrun_o,
  output uop_t uop_o
);
  localparam int LAST = 3*ORDER + 4;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign active_o = active_q;
  assign last_o   = active_q && (cnt_q == CW'(LAST));
  assign accept_o = x_valid_i && (!active_q || last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      active_q  <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= x_valid_i && active_q && !last_o;
      if (accept_o) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (last_o) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // slot program: forward 0..N-1, backward N..2N-1, ladder 2N+1..3N+1
  always_comb begin
    int ci, st;
    uop_o = '0;
    ci    = int'(cnt_q);
    st    = 0;
    if (active_q) begin
      if (ci < ORDER) begin
        st = ORDER - ci;
        uop_o.op      = (ci == 0) ? OP_CSUB : OP_PSUB;
        uop_o.a_idx   = IW'(st - 1);
        uop_o.b_src   = SRC_GD;
        uop_o.b_idx   = IW'(st - 1);
        uop_o.c_src   = SRC_X;
        uop_o.tag.kind = WB_F;
        uop_o.tag.idx  = IW'(st - 1);
      end else if (ci < 2*ORDER) begin
        st = 2*ORDER - ci;
        uop_o.op      = OP_CADD;
        uop_o.a_idx   = IW'(st - 1);
        uop_o.b_src   = SRC_F;
        uop_o.b_idx   = IW'(st - 1);
        uop_o.c_src   = SRC_GD;
        uop_o.c_idx   = IW'(st - 1);
        uop_o.tag.kind = WB_G;
        uop_o.tag.idx  = IW'(st - 1);
      end else if (ci == 2*ORDER + 1) begin
        uop_o.op     = OP_MUL;
        uop_o.a_is_v = 1'b1;
        uop_o.b_src  = SRC_F;
      end else if (ci >= 2*ORDER + 2 && ci <= 3*ORDER + 1) begin
        st = 3*ORDER + 2 - ci;
        uop_o.op     = OP_PADD;
        uop_o.a_is_v = 1'b1;
        uop_o.a_idx  = IW'(st);
        uop_o.b_src  = SRC_G;
        uop_o.b_idx  = IW'(st - 1);
        if (st == 1) uop_o.tag.kind = WB_Y;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= CW'(LAST))); // R6
endmodule

// File: rtl/lattice_ladder_iir.sv
module lattice_ladder_iir import llf_pkg::*; #(
  parameter int ORDER = 5,
  parameter int DW    = 18,
  parameter int FRAC  = 16,
  parameter int AW    = 48,
  parameter int CAW   = $clog2(2*ORDER + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  x_i,
  input  logic           x_valid_i,
  input  logic           coef_we_i,
  input  logic [CAW-1:0] coef_addr_i,
  input  logic [DW-1:0]  coef_data_i,
  output logic [DW-1:0]  y_o,
  output logic           y_valid_o,
  output logic           overrun_o
);
  logic [ORDER-1:0][DW-1:0] k_c;
  logic [ORDER:0][DW-1:0]   v_c;
  logic [ORDER-1:0][DW-1:0] f_q, g_q, gd_q;
  logic [DW-1:0]            x_q;
  logic                     accept, active, last;
  uop_t                     uop;
  logic signed [DW-1:0]     a_val, b_val, c_val, rq;
  logic signed [AW-1:0]     p;
  tag_t                     tag;

  llf_coef_bank #(.ORDER(ORDER), .DW(DW), .CAW(CAW)) u_coef (
    .clk_i, .rst_ni, .we_i(coef_we_i), .addr_i(coef_addr_i),
    .data_i(coef_data_i), .k_o(k_c), .v_o(v_c));

  llf_sched #(.ORDER(ORDER)) u_sched (
    .clk_i, .rst_ni, .x_valid_i, .accept_o(accept), .active_o(active),
    .last_o(last), .overrun_o, .uop_o(uop));

  always_comb begin
    a_val = '0;
    b_val = '0;
    c_val = (uop.c_src == SRC_X) ? x_q : '0;
    for (int i = 0; i < ORDER; i++) begin
      if (!uop.a_is_v && uop.a_idx == IW'(i)) a_val = k_c[i];
      if (uop.b_idx == IW'(i)) begin
        case (uop.b_src)
          SRC_GD:  b_val = gd_q[i];
          SRC_F:   b_val = f_q[i];
          SRC_G:   b_val = g_q[i];
          default: ;
        endcase
      end
      if (uop.c_src == SRC_GD && uop.c_idx == IW'(i)) c_val = gd_q[i];
    end
    for (int i = 0; i <= ORDER; i++)
      if (uop.a_is_v && uop.a_idx == IW'(i)) a_val = v_c[i];
  end

  llf_mac #(.DW(DW), .FRAC(FRAC), .AW(AW)) u_mac (
    .clk_i, .rst_ni, .op_i(uop.op), .a_i(a_val), .b_i(b_val), .c_i(c_val),
    .tag_i(uop.tag), .p_o(p), .tag_o(tag));

  llf_round #(.DW(DW), .FRAC(FRAC), .AW(AW)) u_round (.p_i(p), .q_o(rq));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= '0; g_q <= '0; gd_q <= '0; x_q <= '0;
      y_o <= '0; y_valid_o <= 1'b0;
    end else begin
      y_valid_o <= 1'b0;
      if (accept) x_q <= x_i;
      for (int i = 0; i < ORDER; i++) begin
        if (tag.kind == WB_F && tag.idx == IW'(i)) f_q[i] <= rq;
        if (tag.kind == WB_G && tag.idx == IW'(i)) g_q[i] <= rq;
      end
      if (tag.kind == WB_Y) begin
        y_o       <= rq;
        y_valid_o <= 1'b1;
      end
      // commit delayed backward state
      if (last) begin
        gd_q[0] <= f_q[0];
        for (int i = 1; i < ORDER; i++) gd_q[i] <= g_q[i-1];
      end
    end
  end

  AST_Y_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> $past(last)); // R5
  AST_WB_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag.kind != WB_NONE) |-> active); // R5
  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(gd_q)); // R3
endmodule

// File: tb/tb_lattice_ladder_iir.sv
`timescale 1ns/1ps
module tb_lattice_ladder_iir;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] x_i = '0;
  logic        x_valid_i = 1'b0;
  logic        coef_we_i = 1'b0;
  logic [3:0]  coef_addr_i = '0;
  logic [17:0] coef_data_i = '0;
  logic [17:0] y_o;
  logic        y_valid_o, overrun_o;

  int checks = 0;
  int failures = 0;

  longint mk[1:5];
  longint mv[0:5];
  longint mgd[0:4];

  always #2 clk = ~clk;

  lattice_ladder_iir dut (
    .clk_i(clk), .rst_ni, .x_i, .x_valid_i, .coef_we_i, .coef_addr_i,
    .coef_data_i, .y_o, .y_valid_o, .overrun_o);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mrnd(input longint a);
    longint s;
    s = (a + 32768) >>> 16;
    if (s > 131071) return 131071;
    if (s < -131072) return -131072;
    return s;
  endfunction

  function automatic longint model_step(input longint x);
    longint acc, y;
    longint f[0:4];
    longint g[1:5];
    acc  = (x <<< 16) - mk[5] * mgd[4];
    f[4] = mrnd(acc);
    for (int m = 4; m >= 1; m--) begin
      acc    = acc - mk[m] * mgd[m-1];
      f[m-1] = mrnd(acc);
    end
    for (int i = 1; i <= 5; i++) g[i] = mrnd((mgd[i-1] <<< 16) + mk[i] * f[i-1]);
    acc = mv[0] * f[0];
    for (int i = 1; i <= 5; i++) acc = acc + mv[i] * g[i];
    y = mrnd(acc);
    mgd[0] = f[0];
    for (int i = 1; i <= 4; i++) mgd[i] = g[i];
    return y;
  endfunction

  function automatic longint yv();
    return longint'($signed(y_o));
  endfunction

  task automatic do_reset();
    x_valid_i = 1'b0;
    coef_we_i = 1'b0;
    rst_ni = 1'b0;
    tick(); tick();
    chk(y_o == '0 && !y_valid_o && !overrun_o, "R1 outputs in reset", yv(), 0);
    rst_ni = 1'b1;
    tick();
    chk(y_o == '0 && !y_valid_o && !overrun_o, "R1 outputs after reset", yv(), 0);
    for (int i = 1; i <= 5; i++) mk[i] = 0;
    for (int i = 0; i <= 5; i++) mv[i] = 0;
    for (int i = 0; i <= 4; i++) mgd[i] = 0;
  endtask

  task automatic wr_coef(input int addr, input longint val);
    coef_we_i = 1'b1;
    coef_addr_i = 4'(addr);
    coef_data_i = 18'(val);
    tick();
    coef_we_i = 1'b0;
    if (addr < 5) mk[addr+1] = val;
    else if (addr < 11) mv[addr-5] = val;
  endtask

  task automatic run_sample(input longint x, input string req);
    longint e;
    bit early = 0;
    e = model_step(x);
    x_i = 18'(x);
    x_valid_i = 1'b1;
    tick();
    x_valid_i = 1'b0;
    for (int n = 1; n < 20; n++) begin
      tick();
      if (y_valid_o) early = 1;
    end
    tick();
    chk(y_valid_o && !early, "R5 strobe at cycle 20", longint'(y_valid_o), 1);
    chk(yv() == e, req, yv(), e);
    tick();
    chk(!y_valid_o, "R5 one-cycle strobe", longint'(y_valid_o), 0);
  endtask

  task automatic rand_coefs();
    for (int i = 0; i < 5; i++) wr_coef(i, longint'($urandom_range(0, 131070)) - 65535);
    for (int i = 5; i < 11; i++) wr_coef(i, longint'($urandom_range(0, 65536)) - 32768);
  endtask

  function automatic longint rand_x();
    return longint'($urandom_range(0, 120000)) - 60000;
  endfunction

  task automatic t_zero_coef();
    do_reset();
    run_sample(77777, "R1 zero coefficients give zero output");
  endtask

  task automatic t_delay_line();
    do_reset();
    wr_coef(6, 65536);  // v1 = 1.0 at address 6
    run_sample(5, "R3 delay tap first sample");
    chk(mgd[0] == 5, "R3 model tap", mgd[0], 5);
    run_sample(7, "R3 delay tap y=x[n-1]");
    run_sample(-9, "R3 delay tap y=x[n-1] again");
    chk(mk[1] == 0, "R7 v1 write left k1 untouched", mk[1], 0);
  endtask

  task automatic t_round_sat();
    do_reset();
    wr_coef(5, 32768);  // v0 = 0.5
    run_sample(3, "R4 round half up positive (expect 2)");
    chk(yv() == 2, "R4 rounding 3*0.5", yv(), 2);
    run_sample(-3, "R4 round half up negative (expect -1)");
    chk(yv() == -1, "R4 rounding -3*0.5", yv(), -1);
    do_reset();
    wr_coef(5, 65536);
    wr_coef(6, 65536);
    run_sample(100000, "R4 sum below limit");
    chk(yv() == 100000, "R4 passthrough", yv(), 100000);
    run_sample(100000, "R4 positive saturation");
    chk(yv() == 131071, "R4 positive saturation", yv(), 131071);
    run_sample(-131072, "R4 mixed sum");
    chk(yv() == -31072, "R4 mixed sum", yv(), -31072);
    run_sample(-131072, "R4 negative saturation");
    chk(yv() == -131072, "R4 negative saturation", yv(), -131072);
  endtask

  task automatic t_random();
    do_reset();
    rand_coefs();
    run_sample(rand_x(), "R1 first output from zero state");
    for (int i = 0; i < 30; i++) run_sample(rand_x(), "R2 R3 R8 random recursion");
  endtask

  task automatic t_overrun();
    longint e1;
    e1 = model_step(12345);
    x_i = 18'(12345);
    x_valid_i = 1'b1;
    tick();
    x_valid_i = 1'b0;
    for (int n = 1; n < 5; n++) tick();
    x_i = 18'(-99999);
    x_valid_i = 1'b1;
    tick();  // sampled at edge 5
    x_valid_i = 1'b0;
    chk(overrun_o, "R6 overrun raised", longint'(overrun_o), 1);
    tick();
    chk(!overrun_o, "R6 overrun one cycle", longint'(overrun_o), 0);
    for (int n = 7; n <= 20; n++) tick();
    chk(y_valid_o && yv() == e1, "R6 output unaffected by dropped sample", yv(), e1);
    tick();
    chk(!y_valid_o, "R6 no output for dropped sample", longint'(y_valid_o), 0);
    for (int n = 0; n < 25; n++) begin
      tick();
      if (y_valid_o) chk(0, "R6 stray output after drop", longint'(y_valid_o), 0);
    end
    run_sample(rand_x(), "R6 state unchanged by dropped sample");
  endtask

  task automatic t_back_to_back();
    longint e1, e2;
    e1 = model_step(-4321);
    e2 = model_step(23456);
    x_i = 18'(-4321);
    x_valid_i = 1'b1;
    tick();
    x_valid_i = 1'b0;
    for (int n = 1; n < 20; n++) tick();
    x_i = 18'(23456);
    x_valid_i = 1'b1;
    tick();  // edge 20: accepted in last slot
    x_valid_i = 1'b0;
    chk(y_valid_o && yv() == e1, "R5 first of back-to-back", yv(), e1);
    tick();
    chk(!overrun_o, "R6 last-slot sample accepted", longint'(overrun_o), 0);
    for (int n = 22; n <= 40; n++) tick();
    chk(y_valid_o && yv() == e2, "R6 second of back-to-back", yv(), e2);
    tick();
  endtask

  task automatic t_ignored_addr();
    for (int a = 11; a <= 15; a++) wr_coef(a, 65535 - a);
    for (int i = 0; i < 3; i++) run_sample(rand_x(), "R7 writes to 11..15 ignored");
  endtask

  task automatic t_reset_midrun();
    longint ks[1:5];
    longint vs[0:5];
    for (int i = 1; i <= 5; i++) ks[i] = mk[i];
    for (int i = 0; i <= 5; i++) vs[i] = mv[i];
    x_i = 18'(50000);
    x_valid_i = 1'b1;
    tick();
    x_valid_i = 1'b0;
    for (int n = 0; n < 6; n++) tick();
    do_reset();
    chk(!y_valid_o, "R1 no output after reset mid-run", longint'(y_valid_o), 0);
    for (int i = 1; i <= 5; i++) wr_coef(i - 1, ks[i]);
    for (int i = 0; i <= 5; i++) wr_coef(i + 5, vs[i]);
    run_sample(31000, "R1 zero-state response after reset");
    run_sample(-27000, "R1 R3 state rebuilt after reset");
  endtask

  initial begin
    #(4ns * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 5; i++) mk[i] = 0;
    for (int i = 0; i <= 5; i++) mv[i] = 0;
    for (int i = 0; i <= 4; i++) mgd[i] = 0;
    tick();
    t_zero_coef();
    t_delay_line();
    t_round_sat();
    t_random();
    t_overrun();
    t_back_to_back();
    t_ignored_addr();
    t_reset_midrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule